// File: doc/BRIEF.md
# Delayed Maskable Interrupt Controller

This block gathers single-cycle cause pulses from a receive engine and a transmit engine into a sticky status register. It filters them through a mask register and a global enable, and drives one interrupt line towards the CPU. Raising the line can be put off by a programmable number of clock cycles. This lets several events share one interrupt. Causes that belong to a no-delay set skip the wait. While one assertion is already scheduled, a new request may only pull the deadline earlier and never push it later. Software clears the status by reading it.

The register port is a plain one-cycle strobe interface. A write takes effect at the clock edge where `reg_wr_i` is sampled. A read returns data on `reg_rdata_o` in the cycle after `reg_rd_i` is sampled. There is no back-pressure: the block accepts every strobe. Register addresses are 0 for status (reading it clears it, writes are ignored), 1 for mask, 2 for enable (bit 0), and 3 for delay.

The cause bits, by position, are: 0 receive copy done, 1 receive frame arrived, 2 receive FIFO level, 3 transmit copy done, 4 transmit frame sent, 5 transmit FIFO level. Bits 6 and 7 are reserved.

Top module: `irq_ctrl`

## Requirements
- R1: A post (`cause_vld_i` high) ORs `cause_i` into the status register, and the bits stay set until status is read; posting 0x02 and then 0x08 reads back 0x0A.
- R2: A post that carries any reserved bit (mask 0xC0) is rejected as a whole, leaving status unchanged, and `bad_post_o` is high for the one cycle after it; reserved status bits are never set.
- R3: A status read returns the status value held before the read edge and clears it at that edge; a cause posted in the same cycle as the read is kept.
- R4: With enable set and no masked pending bit in the no-delay set, the line rises exactly D clock edges after the posting edge, where D is the delay register.
- R5: When a masked pending bit is in the no-delay set (bits 2 and 5, mask 0x24), the line rises at the posting edge itself.
- R6: A new request whose deadline is later than the one already scheduled is dropped, and the earlier deadline is kept.
- R7: A new request whose deadline is earlier than the scheduled one replaces it.
- R8: The line is low, and any scheduled deadline is cancelled, whenever status AND mask is zero or the enable is clear.
- R9: Writing the mask with its current value has no effect on the line or the schedule. A changed mask raises the line at once if status AND mask is nonzero, and otherwise drops it.
- R10: Clearing the enable drops the line. Setting it while status AND mask is nonzero raises the line at once.
- R11: After reset the line is low, status is 0, mask is 0x25, enable is 0 and delay is 8.
- R12: Causes outside the mask never raise the line, although they remain visible in status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cause_vld_i | input | 1 | Post strobe for `cause_i` |
| cause_i | input | NC (8) | Cause bits to post |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register select: 0 status, 1 mask, 2 enable, 3 delay |
| reg_wdata_i | input | DATA_W (16) | Write data |
| reg_rdata_o | output | DATA_W (16) | Read data, valid the cycle after the read strobe |
| bad_post_o | output | 1 | One-cycle flag for a rejected post that carried a reserved bit |
| irq_o | output | 1 | Interrupt line to the CPU |

## Verification
The delay path is tested with a masked, delayed cause, and the line is sampled one edge before the deadline and at the deadline. This shows whether the delay is counted exactly. A no-delay cause is then posted against the same delay setting, so an immediate assertion can be told apart from a short countdown. Two second posts are placed against a running countdown, one that would end later and one that would end earlier. The edge on which the line rises shows whether the block drops or replaces the new deadline. Further cases cover an unmasked cause, a repeated mask write, a changed mask, enable toggling, reserved bits, and a post that coincides with a read. Each of these shows whether the line follows status AND mask, and not the raw status or the write strobes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    RA_STATUS = 2'd0,
    RA_MASK   = 2'd1,
    RA_ENABLE = 2'd2,
    RA_DELAY  = 2'd3
  } reg_addr_e;

  // cause bit positions
  localparam int CB_RX_COPY  = 0;
  localparam int CB_RX_FRAME = 1;
  localparam int CB_RX_LEVEL = 2;
  localparam int CB_TX_COPY  = 3;
  localparam int CB_TX_FRAME = 4;
  localparam int CB_TX_LEVEL = 5;

endpackage

// File: rtl/irqc_cause_store.sv
module irqc_cause_store #(
  parameter int              NC   = 8,
  parameter logic [NC-1:0]   RSVD = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          post_vld_i,
  input  logic [NC-1:0] post_bits_i,
  input  logic          rd_clr_i,
  output logic [NC-1:0] stat_q_o,
  output logic [NC-1:0] stat_nxt_o,
  output logic          accepted_o,
  output logic          bad_post_o
);
  logic [NC-1:0] stat_q;
  logic          bad_q;
  logic          hits_rsvd;

  assign hits_rsvd  = |(post_bits_i & RSVD);
  assign accepted_o = post_vld_i && !hits_rsvd;

  // read clears first, a post of the same cycle then survives
  always_comb begin
    stat_nxt_o = rd_clr_i ? '0 : stat_q;
    if (accepted_o) stat_nxt_o = stat_nxt_o | post_bits_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      stat_q <= '0;
      bad_q  <= 1'b0;
    end else begin
      stat_q <= stat_nxt_o;
      bad_q  <= post_vld_i && hits_rsvd;
    end
  end

  assign stat_q_o   = stat_q;
  assign bad_post_o = bad_q;
endmodule

// File: rtl/irqc_cfg.sv
module irqc_cfg
  import irqc_pkg::*;
#(
  parameter int            NC       = 8,
  parameter int            DW       = 16,
  parameter int            DATA_W   = 16,
  parameter logic [NC-1:0] RSVD     = '0,
  parameter logic [NC-1:0] MASK_RST = '0,
  parameter logic [DW-1:0] DLY_RST  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NC-1:0]     mask_q_o,
  output logic [NC-1:0]     mask_nxt_o,
  output logic              en_q_o,
  output logic              en_nxt_o,
  output logic [DW-1:0]     dly_q_o,
  output logic              force_now_o
);
  logic [NC-1:0] mask_q;
  logic          en_q;
  logic [DW-1:0] dly_q;
  logic [NC-1:0] mask_wr_val;
  logic          mask_sel, en_sel, dly_sel;
  logic          mask_chg, en_rise;

  assign mask_sel    = wr_i && (addr_i == RA_MASK);
  assign en_sel      = wr_i && (addr_i == RA_ENABLE);
  assign dly_sel     = wr_i && (addr_i == RA_DELAY);
  assign mask_wr_val = wdata_i[NC-1:0] & ~RSVD;

  // a rewrite of an identical mask is not a change
  assign mask_chg    = mask_sel && (mask_wr_val != mask_q);
  assign en_rise     = en_sel && wdata_i[0] && !en_q;

  assign mask_nxt_o  = mask_chg ? mask_wr_val : mask_q;
  assign en_nxt_o    = en_sel ? wdata_i[0] : en_q;
  assign force_now_o = mask_chg || en_rise;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mask_q <= MASK_RST & ~RSVD;
      en_q   <= 1'b0;
      dly_q  <= DLY_RST;
    end else begin
      mask_q <= mask_nxt_o;
      en_q   <= en_nxt_o;
      if (dly_sel) dly_q <= wdata_i[DW-1:0];
    end
  end

  assign mask_q_o = mask_q;
  assign en_q_o   = en_q;
  assign dly_q_o  = dly_q;
endmodule

// File: rtl/irqc_sched.sv
module irqc_sched #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pend_nxt_i,
  input  logic          post_req_i,
  input  logic          force_now_i,
  input  logic          nodly_hit_i,
  input  logic [DW-1:0] dly_i,
  output logic [DW-1:0] remain_o,
  output logic          irq_o
);
  // remain == 0: nothing scheduled; remain == k: fires at the k-th edge from now
  logic [DW-1:0] remain_q;
  logic          irq_q;
  logic          want;
  logic [DW-1:0] want_d;
  logic          take;

  assign want   = (post_req_i || force_now_i) && pend_nxt_i;
  assign want_d = (force_now_i || nodly_hit_i) ? '0 : dly_i;
  assign take   = want && ((remain_q == '0) || (want_d < remain_q));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      remain_q <= '0;
      irq_q    <= 1'b0;
    end else if (!pend_nxt_i) begin
      remain_q <= '0;
      irq_q    <= 1'b0;
    end else if (take && (want_d == '0)) begin
      remain_q <= '0;
      irq_q    <= 1'b1;
    end else if (take) begin
      remain_q <= want_d;
    end else if (remain_q == DW'(1)) begin
      remain_q <= '0;
      irq_q    <= 1'b1;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - DW'(1);
    end
  end

  assign remain_o = remain_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irqc_pkg::*;
#(
  parameter int            NC         = 8,
  parameter int            DW         = 16,
  parameter int            DATA_W     = 16,
  parameter logic [NC-1:0] RSVD_BITS  = 8'hC0,
  parameter logic [NC-1:0] NODLY_BITS = 8'h24,
  parameter logic [NC-1:0] MASK_RST   = 8'h25,
  parameter logic [DW-1:0] DLY_RST    = 16'd8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cause_vld_i,
  input  logic [NC-1:0]     cause_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              bad_post_o,
  output logic              irq_o
);
  logic [NC-1:0]     stat_q, stat_nxt;
  logic [NC-1:0]     mask_q, mask_nxt;
  logic              en_q, en_nxt;
  logic [DW-1:0]     dly_q;
  logic [DW-1:0]     remain_q;
  logic              accepted, force_now, rd_clr;
  logic              pend_nxt, nodly_hit;
  logic [NC-1:0]     live_nxt;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign rd_clr = reg_rd_i && (reg_addr_i == RA_STATUS);

  irqc_cause_store #(.NC(NC), .RSVD(RSVD_BITS)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .post_vld_i (cause_vld_i),
    .post_bits_i(cause_i),
    .rd_clr_i   (rd_clr),
    .stat_q_o   (stat_q),
    .stat_nxt_o (stat_nxt),
    .accepted_o (accepted),
    .bad_post_o (bad_post_o)
  );

  irqc_cfg #(
    .NC(NC), .DW(DW), .DATA_W(DATA_W), .RSVD(RSVD_BITS),
    .MASK_RST(MASK_RST), .DLY_RST(DLY_RST)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .mask_q_o   (mask_q),
    .mask_nxt_o (mask_nxt),
    .en_q_o     (en_q),
    .en_nxt_o   (en_nxt),
    .dly_q_o    (dly_q),
    .force_now_o(force_now)
  );

  assign live_nxt  = stat_nxt & mask_nxt;
  assign pend_nxt  = en_nxt && (|live_nxt);
  assign nodly_hit = |(live_nxt & NODLY_BITS);

  irqc_sched #(.DW(DW)) u_sched (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_nxt_i (pend_nxt),
    .post_req_i (accepted),
    .force_now_i(force_now),
    .nodly_hit_i(nodly_hit),
    .dly_i      (dly_q),
    .remain_o   (remain_q),
    .irq_o      (irq_o)
  );

  // zero-extended read mux
  always_comb begin
    rd_mux = '0;
    case (reg_addr_i)
      RA_STATUS: rd_mux[NC-1:0] = stat_q;
      RA_MASK:   rd_mux[NC-1:0] = mask_q;
      RA_ENABLE: rd_mux[0]      = en_q;
      default:   rd_mux[DW-1:0] = dly_q;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int            NC   = 8,
  parameter int            DW   = 16,
  parameter logic [NC-1:0] RSVD = '0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cause_vld_i,
  input logic [NC-1:0] cause_i,
  input logic          reg_wr_i,
  input logic          reg_rd_i,
  input logic [1:0]    reg_addr_i,
  input logic          wdata_b0,
  input logic [NC-1:0] stat_q,
  input logic [NC-1:0] mask_q,
  input logic          en_q,
  input logic [DW-1:0] remain_q,
  input logic          bad_post_o,
  input logic          irq_o
);
  // R8
  irq_needs_live_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_q && (|(stat_q & mask_q))));

  // R2
  rsvd_never_stored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & RSVD) == '0);

  // R2
  bad_flag_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_post_o |-> $past(cause_vld_i && (|(cause_i & RSVD))));

  // R3
  read_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == 2'd0 && !cause_vld_i) |=> (stat_q == '0));

  // R10
  enable_off_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 2'd2 && !wdata_b0) |=> !irq_o);

  // R6
  deadline_never_later_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remain_q != '0) |=> (remain_q < $past(remain_q)));
endmodule

bind irq_ctrl irqc_chk #(.NC(NC), .DW(DW), .RSVD(RSVD_BITS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cause_vld_i(cause_vld_i),
  .cause_i    (cause_i),
  .reg_wr_i   (reg_wr_i),
  .reg_rd_i   (reg_rd_i),
  .reg_addr_i (reg_addr_i),
  .wdata_b0   (reg_wdata_i[0]),
  .stat_q     (stat_q),
  .mask_q     (mask_q),
  .en_q       (en_q),
  .remain_q   (remain_q),
  .bad_post_o (bad_post_o),
  .irq_o      (irq_o)
);

// File: tb/sim_irq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ctrl;
  localparam logic [1:0] A_ST = 2'd0, A_MK = 2'd1, A_EN = 2'd2, A_DL = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cause_vld = 1'b0;
  logic [7:0]  cause = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        bad_post;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cause_vld_i(cause_vld), .cause_i(cause),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .bad_post_o(bad_post), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic post(input logic [7:0] b);
    cause_vld = 1'b1; cause = b;
    @(negedge clk);
    cause_vld = 1'b0; cause = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R11 irq", irq, 0);
    chk("R11 bad_post", bad_post, 0);
    rd(A_ST, v); chk("R11 status", v, 16'h0);
    rd(A_MK, v); chk("R11 mask", v, 16'h25);
    rd(A_EN, v); chk("R11 enable", v, 16'h0);
    rd(A_DL, v); chk("R11 delay", v, 16'd8);
  endtask

  task automatic t_delay();
    logic [15:0] v;
    wr(A_EN, 16'h1);
    wr(A_DL, 16'd5);
    post(8'h01);
    chk("R4 low at post edge", irq, 0);
    tick(4); chk("R4 low one edge early", irq, 0);
    tick(1); chk("R4 high at deadline", irq, 1);
    rd(A_ST, v); chk("R3 read value", v, 16'h01);
    chk("R8 drop after read", irq, 0);
    rd(A_ST, v); chk("R3 cleared", v, 16'h0);
    post(8'h01); tick(1);
    rd(A_ST, v); tick(6);
    chk("R8 cancelled schedule", irq, 0);
  endtask

  task automatic t_nodelay();
    logic [15:0] v;
    post(8'h04);
    chk("R5 immediate", irq, 1);
    rd(A_ST, v); chk("R5 status", v, 16'h04);
    chk("R8 low after clear", irq, 0);
  endtask

  task automatic t_unmasked();
    logic [15:0] v;
    post(8'h02); post(8'h08);
    tick(7); chk("R12 unmasked stays low", irq, 0);
    rd(A_ST, v); chk("R1 sticky OR", v, 16'h0A);
  endtask

  task automatic t_coalesce();
    logic [15:0] v;
    wr(A_DL, 16'd10);
    post(8'h01); tick(2); post(8'h01);
    tick(6); chk("R6 low before first deadline", irq, 0);
    tick(1); chk("R6 first deadline kept", irq, 1);
    rd(A_ST, v);
    post(8'h01); tick(1); wr(A_DL, 16'd3); post(8'h01);
    tick(2); chk("R7 low before new deadline", irq, 0);
    tick(1); chk("R7 earlier deadline wins", irq, 1);
    rd(A_ST, v);
  endtask

  task automatic t_mask();
    logic [15:0] v;
    wr(A_DL, 16'd10);
    post(8'h02); chk("R12 bit1 masked off", irq, 0);
    wr(A_MK, 16'h27); chk("R9 changed mask asserts", irq, 1);
    wr(A_MK, 16'h25); chk("R9 changed mask clears", irq, 0);
    rd(A_MK, v); chk("R9 mask readback", v, 16'h25);
    rd(A_ST, v);
    post(8'h01);
    wr(A_MK, 16'h25); chk("R9 same mask no effect", irq, 0);
    tick(8); chk("R9 schedule intact early", irq, 0);
    tick(1); chk("R9 schedule intact fires", irq, 1);
    rd(A_ST, v);
  endtask

  task automatic t_enable();
    logic [15:0] v;
    post(8'h04); chk("R10 setup", irq, 1);
    wr(A_EN, 16'h0); chk("R10 disable drops", irq, 0);
    tick(2); chk("R10 stays low", irq, 0);
    wr(A_EN, 16'h1); chk("R10 enable asserts", irq, 1);
    rd(A_ST, v); chk("R10 status kept", v, 16'h04);
    wr(A_EN, 16'h0); wr(A_DL, 16'd20);
    post(8'h01); tick(3); chk("R10 disabled post low", irq, 0);
    wr(A_EN, 16'h1); chk("R10 enable immediate", irq, 1);
    rd(A_ST, v);
  endtask

  task automatic t_reserved();
    logic [15:0] v;
    post(8'h40);
    chk("R2 flag", bad_post, 1);
    chk("R2 no irq", irq, 0);
    post(8'hC1);
    chk("R2 flag mixed", bad_post, 1);
    tick(1); chk("R2 flag one cycle", bad_post, 0);
    rd(A_ST, v); chk("R2 status untouched", v, 16'h0);
    post(8'h02); chk("R2 legal post no flag", bad_post, 0);
    rd(A_ST, v);
  endtask

  task automatic t_read_post();
    logic [15:0] v;
    post(8'h08);
    reg_rd = 1'b1; reg_addr = A_ST; cause_vld = 1'b1; cause = 8'h10;
    @(negedge clk);
    reg_rd = 1'b0; cause_vld = 1'b0; cause = '0;
    chk("R3 old value returned", reg_rdata, 16'h08);
    rd(A_ST, v); chk("R3 concurrent post kept", v, 16'h10);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_delay();
    t_nodelay();
    t_unmasked();
    t_coalesce();
    t_mask();
    t_enable();
    t_reserved();
    t_read_post();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule